// File: doc/BRIEF.md
# Output-Buffer-Full Interrupt Router

This block takes the two output-buffer-full flags of a keyboard-controller-style host interface and turns them into two interrupt request bits. A serial interrupt encoder reads these bits. Line 0 stands for the keyboard request (IRQ1) and line 1 for the auxiliary-device request (IRQ12). Each flag reaches its line only while a per-line enable bit is set. A small CPU-writable configuration register selects three behaviours:

- **Merge:** the OR of both flags drives both lines.
- **Clear-on-read:** a request stays pending until the host reads the buffer, instead of following the flag level.
- **Sync-cut:** hardware drops both enable bits when either flag goes low.

Firmware writes the configuration and the enable bits through a one-address-bit register port and can read them back. Hardware clears of the enable bits are visible in that readback. In merge mode, one host read can retire both pending requests together, even if the second request was raised by a later overwrite of the buffer. The flags are registered on entry, and the request outputs are registered.

Top module: `obf_irq_merge`

## Requirements
- R1: After reset, the configuration register and the enable register read 0, and both request outputs are 0.
- R2: With merge = 0 and clear-on-read = 0, request line 0 follows flag 0 and line 1 follows flag 1, each gated by its own enable. A flag change shows at the output two clock edges after it is applied. A flag has no effect on the other line.
- R3: With merge = 1 (configuration bit 0), the OR of both flags drives both lines, and each line is gated by its own enable.
- R4: A line whose enable bit is 0 stays 0 whatever the flags do. The enable register holds line 0's enable in bit 0 and line 1's enable in bit 1.
- R5: With clear-on-read = 1 (configuration bit 1), a request is set on a rising edge of its gated source and stays set after the flag falls. It is cleared only by a host read strobe of its own buffer (strobe bit 0 for line 0, bit 1 for line 1).
- R6: With merge = 1 and clear-on-read = 1, one host read strobe on either buffer clears both pending requests on the same edge.
- R7: In clear-on-read mode, a new rising source and a host read in the same cycle leave the request set.
- R8: With sync-cut = 1 (configuration bit 4), a falling edge of either registered flag clears both enable bits on the next clock edge.
- R9: A hardware clear of the enable bits takes priority over a CPU write to the enable register in the same cycle.
- R10: Register address 0 reads back the configuration (bit 0 merge, bit 1 clear-on-read, bit 4 sync-cut, other bits 0). Address 1 reads back the enable bits (bits 7..2 read 0). Both reflect any hardware clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obf_i | input | 2 | Output-buffer-full flags, bit 0 = buffer 0, bit 1 = buffer 1 |
| host_rd_i | input | 2 | One-cycle host read strobes for buffer 0 and buffer 1 |
| cpu_wr_en_i | input | 1 | CPU register write enable |
| cpu_addr_i | input | 1 | Register address for write and readback: 0 configuration, 1 enables |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Readback of the addressed register |
| irq_req_o | output | 2 | Request bits: bit 0 keyboard line, bit 1 auxiliary line |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the sync-cut hardware clear and a CPU write to the enable register. The bench lowers a flag with sync-cut on, waits one edge so that the falling edge is detected, and then holds a write of both enables across the next edge. The enable readback must be 0, because the hardware clear wins.

The second pair, in clear-on-read mode, is a new rising source and a host read strobe. The bench places the read in the cycle in which the registered flag first shows high. The request must end up set.

// File: rtl/obf_pkg.sv
// Shared constants for the output-buffer-full interrupt router.
// Assumes exactly two buffers and two request lines.
package obf_pkg;
    localparam int NUM_LINES   = 2;
    localparam int CPU_DW      = 8;
    // configuration bit positions
    localparam int CFG_MERGE   = 0;
    localparam int CFG_CLRSEL  = 1;
    localparam int CFG_CUT     = 4;
    // register addresses
    localparam logic ADDR_CFG  = 1'b0;
    localparam logic ADDR_EN   = 1'b1;
endpackage

// File: rtl/obf_flag_edge.sv
// Registers the incoming buffer-full flags and flags a falling edge of the
// registered value. Assumes the flags are synchronous to clk.
module obf_flag_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag_i,
    output logic [W-1:0] flag_q_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_qq;

    // two-stage capture of the flags for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= '0;
            flag_qq <= '0;
        end else begin
            flag_q  <= flag_i;
            flag_qq <= flag_q;
        end
    end

    // falling edge of the registered flag
    always_comb begin
        fall_o   = flag_qq & ~flag_q;
        flag_q_o = flag_q;
    end
endmodule

// File: rtl/obf_cfg_regs.sv
// Configuration and per-line enable registers with CPU write and readback.
// The sync-cut hardware clear of the enables beats a same-cycle CPU write.
module obf_cfg_regs
    import obf_pkg::*;
#(
    parameter int DW = CPU_DW,
    parameter int NL = NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          fall_any_i,
    output logic          merge_o,
    output logic          clrsel_o,
    output logic          cut_o,
    output logic [NL-1:0] en_o,
    output logic [DW-1:0] rdata_o
);
    logic          merge_q, clrsel_q, cut_q;
    logic [NL-1:0] en_q;
    logic          auto_clr;

    // hardware clear request for the enables
    always_comb auto_clr = cut_q & fall_any_i;

    // configuration and enable register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merge_q  <= 1'b0;
            clrsel_q <= 1'b0;
            cut_q    <= 1'b0;
            en_q     <= '0;
        end else begin
            if (wr_en_i && addr_i == ADDR_CFG) begin
                merge_q  <= wdata_i[CFG_MERGE];
                clrsel_q <= wdata_i[CFG_CLRSEL];
                cut_q    <= wdata_i[CFG_CUT];
            end
            if (auto_clr)
                en_q <= '0;
            else if (wr_en_i && addr_i == ADDR_EN)
                en_q <= wdata_i[NL-1:0];
        end
    end

    // readback mux of the addressed register
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CFG) begin
            rdata_o[CFG_MERGE]  = merge_q;
            rdata_o[CFG_CLRSEL] = clrsel_q;
            rdata_o[CFG_CUT]    = cut_q;
        end else begin
            rdata_o[NL-1:0] = en_q;
        end
        merge_o  = merge_q;
        clrsel_o = clrsel_q;
        cut_o    = cut_q;
        en_o     = en_q;
    end

    // R1: registers come out of reset cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!merge_q && !clrsel_q && !cut_q && en_q == '0));

    // R8: a detected falling flag under sync-cut empties the enables
    p_sync_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_q && fall_any_i) |=> (en_q == '0));

    // R9: a write to the enables cannot survive a same-cycle hardware clear
    p_cut_beats_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_q && fall_any_i && wr_en_i && addr_i == ADDR_EN) |=> (en_q == '0));
endmodule

// File: rtl/obf_req_line.sv
// One interrupt request line. In level mode it registers its gated source.
// In clear-on-read mode it sets on a source rise and clears on a host read,
// and a rise wins over a read in the same cycle.
module obf_req_line (
    input  logic clk,
    input  logic rst_n,
    input  logic src_raw_i,
    input  logic en_i,
    input  logic clrsel_i,
    input  logic clr_evt_i,
    output logic req_o
);
    logic src, src_q, rise, req_q;

    // gated source and its rising edge
    always_comb begin
        src   = src_raw_i & en_i;
        rise  = src & ~src_q;
        req_o = req_q;
    end

    // request register in level or clear-on-read mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            src_q <= src;
            if (!clrsel_i)
                req_q <= src;
            else if (rise)
                req_q <= 1'b1;
            else if (clr_evt_i)
                req_q <= 1'b0;
        end
    end

    // R4: a disabled line in level mode does not request
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clrsel_i && !en_i) |=> !req_o);

    // R5: a pending request survives until a host read
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clrsel_i && !clr_evt_i && req_o) |=> req_o);

    // R5: a host read with no new source drops the request
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clrsel_i && clr_evt_i && !src_raw_i) |=> !req_o);

    // R7: a source rise with a simultaneous read still sets the request
    p_rise_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clrsel_i && clr_evt_i && src && !src_q) |=> req_o);
endmodule

// File: rtl/obf_irq_merge.sv
// Top of the output-buffer-full interrupt router. Registers the flags,
// picks per-line or merged sources, routes host read strobes to the lines'
// clear inputs and holds the configuration. Assumes all inputs are
// synchronous to clk.
module obf_irq_merge
    import obf_pkg::*;
#(
    parameter int DW = CPU_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    obf_i,
    input  logic [1:0]    host_rd_i,
    input  logic          cpu_wr_en_i,
    input  logic          cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    output logic [1:0]    irq_req_o
);
    localparam int NL = NUM_LINES;

    logic [NL-1:0] flag_q, fall, en;
    logic          merge, clrsel, cut, fall_any;
    logic [NL-1:0] src_raw, clr_evt;

    obf_flag_edge #(.W(NL)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (obf_i),
        .flag_q_o (flag_q),
        .fall_o   (fall)
    );

    // any registered flag falling
    always_comb fall_any = |fall;

    obf_cfg_regs #(.DW(DW), .NL(NL)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cpu_wr_en_i),
        .addr_i     (cpu_addr_i),
        .wdata_i    (cpu_wdata_i),
        .fall_any_i (fall_any),
        .merge_o    (merge),
        .clrsel_o   (clrsel),
        .cut_o      (cut),
        .en_o       (en),
        .rdata_o    (cpu_rdata_o)
    );

    for (genvar i = 0; i < NL; i++) begin : g_line
        // merged or per-line source and clear selection
        always_comb begin
            src_raw[i] = merge ? (|flag_q)    : flag_q[i];
            clr_evt[i] = merge ? (|host_rd_i) : host_rd_i[i];
        end

        obf_req_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_raw_i (src_raw[i]),
            .en_i      (en[i]),
            .clrsel_i  (clrsel),
            .clr_evt_i (clr_evt[i]),
            .req_o     (irq_req_o[i])
        );
    end

    // R3: merged level mode with both lines enabled gives equal requests
    p_merge_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && !clrsel && en == 2'b11) |=> (irq_req_o[0] == irq_req_o[1]));

    // R6: merged read with no flags pending clears both lines together
    p_merge_read_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && clrsel && (|host_rd_i) && flag_q == '0) |=> (irq_req_o == 2'b00));

    // R1: request outputs are low after reset
    p_reset_req_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_req_o == 2'b00));
endmodule

// File: tb/obf_irq_merge_bench.sv
`timescale 1ns/100ps
module obf_irq_merge_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] obf;
    logic [1:0] host_rd;
    logic       wr_en;
    logic       addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    obf_irq_merge u_obf_irq_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .obf_i       (obf),
        .host_rd_i   (host_rd),
        .cpu_wr_en_i (wr_en),
        .cpu_addr_i  (addr),
        .cpu_wdata_i (wdata),
        .cpu_rdata_o (rdata),
        .irq_req_o   (req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    // quiet the flags, then set configuration and enables
    task automatic setup(input logic [7:0] cfg, input logic [1:0] en);
        obf = 2'b00; host_rd = 2'b00;
        step(3);
        wr(1'b0, cfg);
        wr(1'b1, {6'd0, en});
        step(1);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(1'b0, d); check("R1 cfg after reset", d, 8'h00);
        rd(1'b1, d); check("R1 enables after reset", d, 8'h00);
        check("R1 requests after reset", {6'd0, req}, 8'h00);
    endtask

    task automatic t_separate;
        setup(8'h00, 2'b11);
        obf = 2'b01; step(1);
        check("R2 no change after one edge", {6'd0, req}, 8'h00);
        step(1);
        check("R2 flag0 drives line0 only", {6'd0, req}, 8'h01);
        obf = 2'b10; step(2);
        check("R2 flag1 drives line1 only", {6'd0, req}, 8'h02);
        obf = 2'b00; step(2);
        check("R2 lines follow flags low", {6'd0, req}, 8'h00);
    endtask

    task automatic t_merge;
        setup(8'h01, 2'b11);
        obf = 2'b10; step(2);
        check("R3 flag1 merged onto both", {6'd0, req}, 8'h03);
        obf = 2'b01; step(2);
        check("R3 flag0 merged onto both", {6'd0, req}, 8'h03);
        obf = 2'b00; step(2);
        check("R3 merged low", {6'd0, req}, 8'h00);
    endtask

    task automatic t_gate;
        setup(8'h00, 2'b01);
        obf = 2'b11; step(2);
        check("R4 disabled line1 stays low", {6'd0, req}, 8'h01);
        setup(8'h01, 2'b10);
        obf = 2'b01; step(2);
        check("R4 merged, only enabled line1", {6'd0, req}, 8'h02);
    endtask

    task automatic t_rdclr;
        setup(8'h02, 2'b11);
        obf = 2'b01; step(2);
        check("R5 request set on rise", {6'd0, req}, 8'h01);
        obf = 2'b00; step(3);
        check("R5 request held after flag falls", {6'd0, req}, 8'h01);
        host_rd = 2'b10; step(1); host_rd = 2'b00;
        check("R5 other buffer read ignored", {6'd0, req}, 8'h01);
        host_rd = 2'b01; step(1); host_rd = 2'b00;
        check("R5 own read clears", {6'd0, req}, 8'h00);
    endtask

    task automatic t_merge_rdclr;
        setup(8'h03, 2'b11);
        obf = 2'b01; step(2);
        obf = 2'b11; step(2);
        check("R6 both pending", {6'd0, req}, 8'h03);
        host_rd = 2'b01; step(1); host_rd = 2'b00;
        check("R6 one read clears both", {6'd0, req}, 8'h00);
    endtask

    task automatic t_rise_vs_read;
        setup(8'h02, 2'b11);
        obf = 2'b01; step(1);
        host_rd = 2'b01; step(1); host_rd = 2'b00;
        check("R7 rise wins over read", {6'd0, req}, 8'h01);
    endtask

    task automatic t_cut;
        logic [7:0] d;
        setup(8'h10, 2'b11);
        obf = 2'b01; step(2);
        obf = 2'b00; step(1);
        rd(1'b1, d); check("R8 enables kept until next edge", d, 8'h03);
        step(1);
        rd(1'b1, d); check("R8 enables cleared after fall", d, 8'h00);
        rd(1'b0, d); check("R10 cfg readback", d, 8'h10);
    endtask

    task automatic t_cut_vs_write;
        logic [7:0] d;
        setup(8'h10, 2'b11);
        obf = 2'b10; step(2);
        obf = 2'b00; step(1);
        wr(1'b1, 8'h03);
        rd(1'b1, d); check("R9 hardware clear beats write", d, 8'h00);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        setup(8'hFF, 2'b10);
        rd(1'b0, d); check("R10 cfg reads only defined bits", d, 8'h13);
        rd(1'b1, d); check("R10 enables readback", d, 8'h02);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; obf = 2'b00; host_rd = 2'b00;
        wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_separate();
        t_merge();
        t_gate();
        t_rdclr();
        t_merge_rdclr();
        t_rise_vs_read();
        t_cut();
        t_cut_vs_write();
        t_readback();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule